// File: doc/BRIEF.md
# External Coherency Request Responder

This block serves the snoop side of a secondary cache. A system bus hands it coherency requests, each carrying a request kind and a line address. For every request it looks up a small direct-mapped tag and state array, works out the line's former coherency state, writes the new state back, and returns exactly one state response that carries the former state. Interventions that find a line in the dirty exclusive state also ask, through a pulse output, for the line's data to be sent. Invalidates that find an exclusive line are treated as a protocol fault and latch a sticky error flag.

Requests enter a small queue through a valid/ready port and are served one at a time from its head. Responses leave in arrival order through a valid/ready port. A fill port lets the surrounding logic, or a bench, load tags and states into the array directly.

Top module: `coh_snoop_responder`

## Requirements
- R1: After reset `resp_valid`, `data_pulse` and `proto_err` are 0, `req_ready` is 1 and every line is Invalid.
- R2: Line states use 2 bits: Invalid=00, Shared=01, CleanExclusive=10, DirtyExclusive=11. Each accepted request gives exactly one response whose `resp_state` is the line's former state. With an empty queue and `resp_ready` high, the response is valid one clock edge after the edge that accepts the request.
- R3: Responses leave strictly in the order in which the requests were accepted.
- R4: Request kind 00 (intervention for a shared copy) that hits a valid line sets it to Shared.
- R5: Request kind 01 (intervention for an exclusive copy) that hits a valid line sets it to Invalid.
- R6: Request kind 10 (invalidate) that hits a valid line sets it to Invalid. The reserved kind 11 is handled exactly as an invalidate.
- R7: `data_pulse` is high only in a cycle where a response is being accepted (`resp_valid` and `resp_ready`), and only when that response belongs to a kind 00 or 01 request whose line was DirtyExclusive.
- R8: An invalidate that hits a CleanExclusive or DirtyExclusive line still invalidates it and sets `proto_err`, which then stays high until reset.
- R9: The address splits into index = `req_addr[IDX_W-1:0]` and tag = the upper bits. A request whose tag does not match, or whose line is Invalid, reports Invalid, changes no line, gives no data pulse and sets no error.
- R10: The queue holds 4 requests. `req_ready` is low while it is full. A response that is held back by `resp_ready` low keeps `resp_valid` and `resp_state` unchanged.
- R11: A fill write (`fill_en` high) stores `fill_tag` and `fill_state` in line `fill_idx`, and any request accepted after that edge sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The queue can take a request |
| req_kind | input | 2 | Request kind (00, 01, 10, reserved 11) |
| req_addr | input | ADDR_W | Line address (tag and index) |
| resp_valid | output | 1 | A state response is offered |
| resp_ready | input | 1 | The bus takes the response |
| resp_state | output | 2 | Former state of the line |
| data_pulse | output | 1 | Send the line's data for the response being accepted |
| proto_err | output | 1 | Sticky flag: invalidate found an exclusive line |
| fill_en | input | 1 | Write one line through the fill port |
| fill_idx | input | IDX_W | Line to write |
| fill_tag | input | ADDR_W-IDX_W | Tag to store |
| fill_state | input | 2 | State to store |

## Verification
A request that is accepted at one edge into an empty queue is served at the next edge, so its response, its data pulse and any error flag are sampled on the falling edge after that second edge; the bench drives on falling edges and reads there, never on the active edge. The line's new state is not a port, so the bench reads it back by sending a kind 00 probe to the same address after the response, and the probe's own response is due with the same one-edge delay. In the backpressure test the response is held for several cycles and then drained at one per edge, and each response is sampled on the falling edge before the edge that takes it.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    ST_INV = 2'b00,
    ST_SHD = 2'b01,
    ST_CEX = 2'b10,
    ST_DEX = 2'b11
  } line_st_t;

  typedef enum logic [1:0] {
    RQ_ISH = 2'b00,
    RQ_IEX = 2'b01,
    RQ_INV = 2'b10,
    RQ_RSV = 2'b11
  } req_kind_t;

  // State written back after a hit.
  function automatic line_st_t next_state(input req_kind_t kind, input line_st_t former);
    if (former == ST_INV) return ST_INV;
    if (kind == RQ_ISH)   return ST_SHD;
    return ST_INV;
  endfunction

  // An intervention finding modified data must source it.
  function automatic logic wants_data(input req_kind_t kind, input line_st_t former);
    return (kind == RQ_ISH || kind == RQ_IEX) && (former == ST_DEX);
  endfunction

  // Invalidate (or reserved kind) landing on an exclusive line.
  function automatic logic is_abnormal(input req_kind_t kind, input line_st_t former);
    return kind[1] && former[1];
  endfunction

endpackage

// File: rtl/coh_req_fifo.sv
module coh_req_fifo #(
  parameter int WIDTH = 10,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             not_empty,
  output logic             full,
  output logic [$clog2(DEPTH):0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [$clog2(DEPTH):0] cnt_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  wire do_push = push && !full;
  wire do_pop  = pop && not_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) begin
        mem[wr_ptr] <= din;
        wr_ptr      <= bump(wr_ptr);
      end
      if (do_pop) rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign dout      = mem[rd_ptr];
  assign not_empty = (cnt_q != '0);
  assign full      = (cnt_q == ($clog2(DEPTH)+1)'(DEPTH));
  assign count     = cnt_q;
endmodule

// File: rtl/coh_tag_array.sv
module coh_tag_array
  import coh_pkg::*;
#(
  parameter int LINES = 16,
  parameter int TAG_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(LINES)-1:0] rd_idx,
  output logic [TAG_W-1:0]         rd_tag,
  output line_st_t                 rd_state,
  input  logic                     upd_en,
  input  logic [$clog2(LINES)-1:0] upd_idx,
  input  line_st_t                 upd_state,
  input  logic                     fill_en,
  input  logic [$clog2(LINES)-1:0] fill_idx,
  input  logic [TAG_W-1:0]         fill_tag,
  input  line_st_t                 fill_state
);
  typedef struct packed {
    logic [TAG_W-1:0] tag;
    line_st_t         st;
  } line_t;

  line_t lines [LINES];

  // The fill write is issued last, so it wins a same-line collision.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) lines[i] <= '{tag: '0, st: ST_INV};
    end else begin
      if (upd_en)  lines[upd_idx].st <= upd_state;
      if (fill_en) lines[fill_idx]   <= '{tag: fill_tag, st: fill_state};
    end
  end

  assign rd_tag   = lines[rd_idx].tag;
  assign rd_state = lines[rd_idx].st;
endmodule

// File: rtl/coh_snoop_engine.sv
module coh_snoop_engine
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                head_valid,
  input  req_kind_t           head_kind,
  input  logic [ADDR_W-1:0]   head_addr,
  output logic                head_pop,
  output logic [IDX_W-1:0]    look_idx,
  input  logic [ADDR_W-IDX_W-1:0] look_tag,
  input  line_st_t            look_state,
  output logic                upd_en,
  output line_st_t            upd_state,
  output logic                resp_valid,
  input  logic                resp_ready,
  output line_st_t            resp_state,
  output logic                data_pulse,
  output logic                proto_err,
  output logic                fire,
  output logic                hit,
  output line_st_t            former
);
  logic rv_q, dirty_q, err_q;
  line_st_t rs_q;

  assign look_idx  = head_addr[IDX_W-1:0];
  assign hit       = (look_state != ST_INV) && (look_tag == head_addr[ADDR_W-1:IDX_W]);
  assign former    = hit ? look_state : ST_INV;
  assign fire      = head_valid && (!rv_q || resp_ready);
  assign head_pop  = fire;
  assign upd_en    = fire && hit;
  assign upd_state = next_state(head_kind, former);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rv_q    <= 1'b0;
      rs_q    <= ST_INV;
      dirty_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (fire) begin
        rv_q    <= 1'b1;
        rs_q    <= former;
        dirty_q <= wants_data(head_kind, former);
      end else if (resp_ready) begin
        rv_q    <= 1'b0;
        dirty_q <= 1'b0;
      end
      if (fire && is_abnormal(head_kind, former)) err_q <= 1'b1;
    end
  end

  assign resp_valid = rv_q;
  assign resp_state = rs_q;
  assign data_pulse = rv_q && resp_ready && dirty_q;
  assign proto_err  = err_q;
endmodule

// File: rtl/coh_snoop_responder.sv
module coh_snoop_responder
  import coh_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int LINES   = 16,
  parameter int Q_DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [1:0]                   req_kind,
  input  logic [ADDR_W-1:0]            req_addr,
  output logic                         resp_valid,
  input  logic                         resp_ready,
  output logic [1:0]                   resp_state,
  output logic                         data_pulse,
  output logic                         proto_err,
  input  logic                         fill_en,
  input  logic [$clog2(LINES)-1:0]     fill_idx,
  input  logic [ADDR_W-$clog2(LINES)-1:0] fill_tag,
  input  logic [1:0]                   fill_state
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int ENT_W = ADDR_W + 2;

  // Named internal events, used by the bound checker.
  logic                  q_full, q_nempty, q_pop;
  logic [ENT_W-1:0]      q_head;
  logic [$clog2(Q_DEPTH):0] q_count;
  logic                  proc_fire, proc_hit;
  line_st_t              proc_former;
  req_kind_t             proc_kind;
  logic [IDX_W-1:0]      look_idx;
  logic [TAG_W-1:0]      look_tag;
  line_st_t              look_state, upd_state, resp_st;
  logic                  upd_en;

  assign req_ready = !q_full;
  assign proc_kind = req_kind_t'(q_head[ENT_W-1 -: 2]);

  coh_req_fifo #(.WIDTH(ENT_W), .DEPTH(Q_DEPTH)) u_fifo (
    .clk, .rst_n,
    .push(req_valid), .din({req_kind, req_addr}),
    .pop(q_pop), .dout(q_head),
    .not_empty(q_nempty), .full(q_full), .count(q_count)
  );

  coh_tag_array #(.LINES(LINES), .TAG_W(TAG_W)) u_array (
    .clk, .rst_n,
    .rd_idx(look_idx), .rd_tag(look_tag), .rd_state(look_state),
    .upd_en(upd_en), .upd_idx(look_idx), .upd_state(upd_state),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag),
    .fill_state(line_st_t'(fill_state))
  );

  coh_snoop_engine #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_engine (
    .clk, .rst_n,
    .head_valid(q_nempty), .head_kind(proc_kind),
    .head_addr(q_head[ADDR_W-1:0]), .head_pop(q_pop),
    .look_idx(look_idx), .look_tag(look_tag), .look_state(look_state),
    .upd_en(upd_en), .upd_state(upd_state),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_state(resp_st),
    .data_pulse(data_pulse), .proto_err(proto_err),
    .fire(proc_fire), .hit(proc_hit), .former(proc_former)
  );

  assign resp_state = resp_st;
endmodule

// File: rtl/coh_snoop_checker.sv
module coh_snoop_checker #(
  parameter int Q_DEPTH = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      resp_valid,
  input logic                      resp_ready,
  input logic [1:0]                resp_state,
  input logic                      data_pulse,
  input logic                      proto_err,
  input logic [$clog2(Q_DEPTH):0]  q_count,
  input logic                      proc_fire,
  input logic                      proc_hit,
  input logic [1:0]                proc_kind,
  input logic [1:0]                proc_former
);
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= ($clog2(Q_DEPTH)+1)'(Q_DEPTH));

  p_hold_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_state));

  p_pulse_on_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    data_pulse |-> resp_valid && resp_ready && resp_state == 2'b11);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  p_err_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    proc_fire && proc_hit && proc_kind[1] && proc_former[1] |=> proto_err);

  p_one_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    proc_fire |=> resp_valid);

  p_miss_invalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    proc_fire && !proc_hit |=> resp_state == 2'b00 && !data_pulse);
endmodule

bind coh_snoop_responder coh_snoop_checker #(.Q_DEPTH(Q_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_state(resp_state),
  .data_pulse(data_pulse), .proto_err(proto_err), .q_count(q_count),
  .proc_fire(proc_fire), .proc_hit(proc_hit),
  .proc_kind(proc_kind), .proc_former(proc_former)
);

// File: tb/coh_snoop_responder_bench.sv
module coh_snoop_responder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int IDX_W  = 4;
  localparam int TAG_W  = ADDR_W - IDX_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_kind = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic resp_valid, resp_ready = 1'b1;
  logic [1:0] resp_state;
  logic data_pulse, proto_err;
  logic fill_en = 1'b0;
  logic [IDX_W-1:0] fill_idx = '0;
  logic [TAG_W-1:0] fill_tag = '0;
  logic [1:0] fill_state = '0;

  int n_cmp = 0, n_bad = 0;
  bit exp_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  coh_snoop_responder u_coh_snoop_responder (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_next(input int k, input int s);
    if (s == 0) return 0;
    return (k == 0) ? 1 : 0;
  endfunction

  task automatic fill(input int idx, input int tag, input int st);
    @(negedge clk);
    fill_en = 1; fill_idx = IDX_W'(idx); fill_tag = TAG_W'(tag); fill_state = 2'(st);
    @(negedge clk);
    fill_en = 0;
  endtask

  // Send one request to an idle block and take its response.
  task automatic do_req(input int k, input int addr, output int st, output int pl);
    @(negedge clk);
    req_valid = 1; req_kind = 2'(k); req_addr = ADDR_W'(addr);
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
    chk(resp_valid == 1, "R2 response one edge after accept", int'(resp_valid), 1);
    st = int'(resp_state);
    pl = int'(data_pulse);
  endtask

  initial begin : main
    int st, pl;
    int bp_st[5] = '{1, 2, 3, 0, 3};
    int bp_k[5]  = '{0, 0, 1, 0, 2};
    int bp_pl[5] = '{0, 0, 1, 0, 0};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(resp_valid == 0, "R1 resp_valid", int'(resp_valid), 0);
    chk(data_pulse == 0, "R1 data_pulse", int'(data_pulse), 0);
    chk(proto_err == 0, "R1 proto_err", int'(proto_err), 0);
    chk(req_ready == 1, "R1 req_ready", int'(req_ready), 1);
    for (int i = 0; i < 16; i++) begin
      do_req(0, (i * 16) + i, st, pl);
      chk(st == 0, "R1 line invalid after reset", st, 0);
    end

    // R9: tag misses, every kind on a DirtyExclusive line
    for (int k = 0; k < 4; k++) begin
      int idx = 8 + k, tag = 3 + k;
      fill(idx, tag, 3);
      do_req(k, ((tag ^ 1) << IDX_W) | idx, st, pl);
      chk(st == 0, "R9 miss reports Invalid", st, 0);
      chk(pl == 0, "R9 miss no data pulse", pl, 0);
      @(negedge clk);
      chk(proto_err == 0, "R9 miss sets no error", int'(proto_err), 0);
      do_req(0, (tag << IDX_W) | idx, st, pl);
      chk(st == 3, "R9 R11 line unchanged after miss", st, 3);
    end

    // Full sweep of kind x former state
    for (int k = 0; k < 4; k++) begin
      for (int s = 0; s < 4; s++) begin
        int idx = (k * 4 + s) % 16, tag = (k + s + 5) % 16, a, nx, ep;
        a = (tag << IDX_W) | idx;
        fill(idx, tag, s);
        do_req(k, a, st, pl);
        chk(st == s, "R2 R11 former state", st, s);
        ep = (k < 2 && s == 3) ? 1 : 0;
        chk(pl == ep, "R7 data pulse", pl, ep);
        if (k >= 2 && s >= 2) exp_err = 1;
        @(negedge clk);
        chk(proto_err == exp_err, "R8 sticky error", int'(proto_err), int'(exp_err));
        nx = exp_next(k, s);
        do_req(0, a, st, pl);
        if (k == 0)      chk(st == nx, "R4 shared intervention next state", st, nx);
        else if (k == 1) chk(st == nx, "R5 exclusive intervention next state", st, nx);
        else             chk(st == nx, "R6 invalidate next state", st, nx);
      end
    end

    // R3 / R10: ordering and backpressure
    for (int i = 0; i < 5; i++) fill(i, 5, bp_st[i]);
    @(negedge clk);
    resp_ready = 0;
    for (int i = 0; i < 5; i++) begin
      req_valid = 1; req_kind = 2'(bp_k[i]); req_addr = ADDR_W'((5 << IDX_W) | i);
      @(negedge clk);
    end
    req_valid = 0;
    chk(req_ready == 0, "R10 ready low when queue full", int'(req_ready), 0);
    repeat (3) begin
      @(negedge clk);
      chk(resp_valid == 1 && resp_state == 1, "R10 held response stable",
          int'(resp_state), 1);
      chk(data_pulse == 0, "R7 no pulse while not accepted", int'(data_pulse), 0);
    end
    resp_ready = 1;
    for (int i = 0; i < 5; i++) begin
      #1;
      chk(resp_valid == 1, "R3 response present in order", int'(resp_valid), 1);
      chk(int'(resp_state) == bp_st[i], "R3 response order", int'(resp_state), bp_st[i]);
      chk(int'(data_pulse) == bp_pl[i], "R7 pulse on its own response",
          int'(data_pulse), bp_pl[i]);
      @(negedge clk);
    end
    chk(resp_valid == 0, "R2 no extra response", int'(resp_valid), 0);
    chk(proto_err == 1, "R8 error stays set", int'(proto_err), 1);
    do_req(0, (5 << IDX_W) | 2, st, pl);
    chk(st == 0, "R5 line invalid after queued exclusive intervention", st, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule